// File: doc/BRIEF.md
# Posit Quire Accumulator Unit

This unit keeps a 512-bit exact accumulator (a quire) for sums of products of 32-bit posits whose exponent field is two bits wide. Each multiply command decodes two posit operands into sign, power-of-two scale and significand, multiplies the significands exactly, shifts the product so its binary point lines up with the accumulator's binary point, and adds it to or subtracts it from the accumulator. No rounding takes place anywhere, so long dot products come out exact.

The accumulator is a two's complement fixed-point number with 240 fractional bits. Besides the multiply commands, the unit can clear the accumulator or negate it. The whole 512-bit value is always visible on an output and can be overwritten in one cycle through a load port. Not-a-Real (NaR) follows posit rules: a NaR operand poisons the accumulator, and only a clear brings it back.

Every command takes two cycles. The operands are decoded and the product is aligned in the first cycle. The accumulator is updated in the second cycle, and a one-cycle done pulse marks that update.

Top module: `posit_quire_unit`

## Requirements
- R1: After synchronous reset, `acc_q` is all zeros and both `busy` and `done` are low.
- R2: A command is accepted on a clock edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly one cycle. In the following cycle `done` is high for one cycle, and `acc_q` already shows the result. `cmd_valid` is ignored while `busy` is high.
- R3: Opcode 2'b00 (clear) sets the accumulator to zero, whatever its previous value, including NaR.
- R4: Opcode 2'b01 (negate) replaces the accumulator with its two's complement (invert and add one, carry dropped). A zero accumulator stays zero, and a NaR accumulator stays NaR.
- R5: Opcode 2'b10 (multiply-add) adds the exact product of the two posit operands, with 240 fractional bits. For example, 1.0 × 1.0 (0x40000000 twice) adds 2^240, which is bit 240.
- R6: Opcode 2'b11 (multiply-subtract) subtracts the exact product of the two operands from the accumulator.
- R7: If either operand of a multiply-add or multiply-subtract is NaR (0x80000000), the accumulator becomes the NaR pattern: bit 511 set and every other bit clear.
- R8: While the accumulator holds NaR, multiply-add, multiply-subtract and negate all leave it NaR.
- R9: A multiply-add or multiply-subtract with a zero operand (0x00000000) and no NaR operand leaves the accumulator unchanged.
- R10: When `load_valid` is high on an edge where `busy` and `cmd_valid` are both low, `acc_q` shows `load_data` after that edge. At any other time the load is ignored.
- R11: Operands are decoded as posits with a 2-bit exponent field. Negative values are two's complemented first, then the regime run, the exponent and the fraction are read in that order, and scale = 4·regime + exponent. At the extremes, minpos × minpos (0x00000001 squared) adds bit 0, and maxpos × maxpos (0x7FFFFFFF squared) adds bit 480.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 clear, 01 negate, 10 multiply-add, 11 multiply-subtract |
| cmd_a | input | 32 | First posit operand |
| cmd_b | input | 32 | Second posit operand |
| load_valid | input | 1 | Request to overwrite the accumulator |
| load_data | input | 512 | Value to load |
| busy | output | 1 | Command in flight |
| done | output | 1 | One-cycle pulse when a command's result is written |
| acc_q | output | 512 | Accumulator contents |
| acc_nar | output | 1 | Accumulator holds the NaR pattern |

## Verification
The assertions check the rules that hold on every cycle. These are the one-cycle busy window and the following done pulse, NaR stickiness, NaR poisoning from an operand, clear and load results, zero held under negate, a zero operand leaving the accumulator untouched, and a nonzero product always landing inside the accumulator. Whether the product lands at exactly the right bit, with the right sign, can only be shown by the bench. It compares every result with a reference accumulator fed by an independent, bit-walking posit decoder. The stimulus covers directed extremes (minpos, maxpos, ±1.0, zero, NaR) and seeded random command mixes.

// File: rtl/posit_quire_pkg.sv
package posit_quire_pkg;
  localparam int PW    = 32;              // posit width
  localparam int ES    = 2;               // exponent field width
  localparam int QW    = 512;             // accumulator width
  localparam int QFRAC = 240;             // fractional bits of accumulator
  localparam int SIGW  = PW - 3 - ES + 1; // hidden one plus fraction
  localparam int PRODW = 2 * SIGW;
  localparam int FRACP = 2 * (SIGW - 1);  // fractional bits of the product
  localparam int SCW   = 10;              // signed scale width
  localparam int RUNW  = $clog2(PW) + 1;

  typedef enum logic [1:0] {
    OP_CLEAR  = 2'b00,
    OP_NEGATE = 2'b01,
    OP_MADD   = 2'b10,
    OP_MSUB   = 2'b11
  } qop_e;

  typedef struct packed {
    logic                  is_zero;
    logic                  is_nar;
    logic                  neg;
    logic signed [SCW-1:0] scale;
    logic [SIGW-1:0]       sig;
  } pdec_t;
endpackage

// File: rtl/posit_decode.sv
module posit_decode
  import posit_quire_pkg::*;
(
  input  logic [PW-1:0] bits_i,
  output pdec_t         dec_o
);
  logic [PW-1:0]         mag;
  logic [PW-2:0]         body, rest;
  logic [RUNW-1:0]       run, shamt;
  logic                  lead, found;
  logic signed [SCW-1:0] kval;
  logic [ES-1:0]         expv;

  always_comb begin
    mag   = bits_i[PW-1] ? (~bits_i + 1'b1) : bits_i;
    body  = mag[PW-2:0];
    lead  = body[PW-2];
    run   = '0;
    found = 1'b0;
    for (int i = PW - 2; i >= 0; i--) begin
      if (!found) begin
        if (body[i] == lead) run = run + 1'b1;
        else                 found = 1'b1;
      end
    end
    shamt = run + 1'b1;               // skip the run and its terminator
    rest  = body << shamt;
    expv  = rest[PW-2 -: ES];
    kval  = lead ? ($signed({{(SCW-RUNW){1'b0}}, run}) - SCW'(1))
                 : -$signed({{(SCW-RUNW){1'b0}}, run});
    dec_o.scale   = (kval <<< ES) + $signed({{(SCW-ES){1'b0}}, expv});
    dec_o.sig     = {1'b1, rest[PW-2-ES -: SIGW-1]};
    dec_o.neg     = bits_i[PW-1];
    dec_o.is_zero = (bits_i == '0);
    dec_o.is_nar  = (bits_i == {1'b1, {(PW-1){1'b0}}});
  end
endmodule

// File: rtl/posit_product_align.sv
module posit_product_align
  import posit_quire_pkg::*;
(
  input  pdec_t         a_i,
  input  pdec_t         b_i,
  output logic [QW-1:0] mag_o,
  output logic          neg_o
);
  localparam int EXTW = QW + FRACP;

  logic [PRODW-1:0]      prod;
  logic signed [SCW-1:0] pos;
  logic [EXTW-1:0]       ext;

  always_comb begin
    prod  = a_i.sig * b_i.sig;
    pos   = a_i.scale + b_i.scale + SCW'(QFRAC);
    ext   = EXTW'(prod) << $unsigned(pos);
    mag_o = ext[FRACP +: QW];
    neg_o = a_i.neg ^ b_i.neg;
  end
endmodule

// File: rtl/quire_accum.sv
module quire_accum
  import posit_quire_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          upd_i,
  input  qop_e          op_i,
  input  logic [QW-1:0] mag_i,
  input  logic          neg_i,
  input  logic          nar_i,
  input  logic          zero_i,
  input  logic          load_i,
  input  logic [QW-1:0] load_data_i,
  output logic [QW-1:0] acc_o,
  output logic          nar_o
);
  localparam logic [QW-1:0] NAR_PAT = {1'b1, {(QW-1){1'b0}}};

  logic [QW-1:0] acc, nxt;
  logic          is_mac, do_sub;

  assign nar_o  = (acc == NAR_PAT);
  assign acc_o  = acc;
  assign is_mac = (op_i == OP_MADD) || (op_i == OP_MSUB);
  assign do_sub = (op_i == OP_MSUB) ^ neg_i;

  always_comb begin
    nxt = acc;
    if (load_i) begin
      nxt = load_data_i;
    end else if (upd_i) begin
      case (op_i)
        OP_CLEAR:  nxt = '0;
        OP_NEGATE: nxt = ~acc + 1'b1;
        default: begin
          if (nar_i)                nxt = NAR_PAT;
          else if (nar_o || zero_i) nxt = acc;
          else if (do_sub)          nxt = acc - mag_i;
          else                      nxt = acc + mag_i;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) acc <= '0;
    else     acc <= nxt;
  end

  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (upd_i && op_i == OP_CLEAR) |=> (acc == '0));
  a_r4_negate_zero: assert property (@(posedge clk) disable iff (rst)
    (upd_i && op_i == OP_NEGATE && acc == '0) |=> (acc == '0));
  a_r7_nar_operand: assert property (@(posedge clk) disable iff (rst)
    (upd_i && is_mac && nar_i) |=> nar_o);
  a_r8_nar_sticky: assert property (@(posedge clk) disable iff (rst)
    (upd_i && op_i != OP_CLEAR && nar_o) |=> nar_o);
  a_r9_zero_noop: assert property (@(posedge clk) disable iff (rst)
    (upd_i && is_mac && zero_i && !nar_i) |=> $stable(acc));
  a_r10_load: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (acc == $past(load_data_i)));
endmodule

// File: rtl/posit_quire_unit.sv
module posit_quire_unit
  import posit_quire_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [PW-1:0] cmd_a,
  input  logic [PW-1:0] cmd_b,
  input  logic          load_valid,
  input  logic [QW-1:0] load_data,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] acc_q,
  output logic          acc_nar
);
  pdec_t         dec_a, dec_b;
  logic [QW-1:0] al_mag;
  logic          al_neg;
  logic          accept, load_go;

  qop_e          s1_op;
  logic [QW-1:0] s1_mag;
  logic          s1_neg, s1_nar, s1_zero;

  posit_decode u_dec_a (.bits_i(cmd_a), .dec_o(dec_a));
  posit_decode u_dec_b (.bits_i(cmd_b), .dec_o(dec_b));

  posit_product_align u_align (
    .a_i(dec_a), .b_i(dec_b), .mag_o(al_mag), .neg_o(al_neg)
  );

  assign accept  = cmd_valid && !busy;
  assign load_go = load_valid && !busy && !cmd_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      s1_op   <= OP_CLEAR;
      s1_mag  <= '0;
      s1_neg  <= 1'b0;
      s1_nar  <= 1'b0;
      s1_zero <= 1'b0;
    end else begin
      busy <= accept;
      done <= busy;
      if (accept) begin
        s1_op   <= qop_e'(cmd_op);
        s1_mag  <= al_mag;
        s1_neg  <= al_neg;
        s1_nar  <= dec_a.is_nar || dec_b.is_nar;
        s1_zero <= dec_a.is_zero || dec_b.is_zero;
      end
    end
  end

  quire_accum u_acc (
    .clk(clk), .rst(rst), .upd_i(busy), .op_i(s1_op), .mag_i(s1_mag),
    .neg_i(s1_neg), .nar_i(s1_nar), .zero_i(s1_zero), .load_i(load_go),
    .load_data_i(load_data), .acc_o(acc_q), .nar_o(acc_nar)
  );

  a_r2_accept_busy: assert property (@(posedge clk) disable iff (rst)
    accept |=> busy);
  a_r2_busy_single: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy && done));
  a_r2_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r5_product_lands: assert property (@(posedge clk) disable iff (rst)
    (busy && s1_op inside {OP_MADD, OP_MSUB} && !s1_zero && !s1_nar) |-> (s1_mag != '0));
endmodule

// File: tb/posit_quire_unit_test.sv
module posit_quire_unit_test;
  localparam logic [511:0] NAR = {1'b1, 511'd0};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0;
  logic [1:0]   cmd_op = 2'b00;
  logic [31:0]  cmd_a = '0, cmd_b = '0;
  logic         load_valid = 1'b0;
  logic [511:0] load_data = '0;
  logic         busy, done, acc_nar;
  logic [511:0] acc_q;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  logic [511:0] model = '0;

  posit_quire_unit uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_a(cmd_a), .cmd_b(cmd_b), .load_valid(load_valid),
    .load_data(load_data), .busy(busy), .done(done), .acc_q(acc_q),
    .acc_nar(acc_nar)
  );

  always #2 clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected < 100000", cycles);
      summary();
    end
  end

  task automatic check(input string req, input logic [511:0] got, input logic [511:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  // Bit-walking reference decoder: value = sig * 2^(scale - nf)
  function automatic void ref_decode(input logic [31:0] p, output bit ng,
                                     output int scale, output logic [511:0] sig,
                                     output int nf);
    logic [31:0] m;
    int i, run, k, e;
    bit r;
    m  = p[31] ? (~p + 32'd1) : p;
    ng = p[31];
    i = 30; r = m[30]; run = 0;
    while (i >= 0 && m[i] == r) begin run++; i--; end
    k = r ? run - 1 : -run;
    i--;
    e = 0;
    for (int j = 0; j < 2; j++) begin
      e = e * 2;
      if (i >= 0) begin e = e + int'(m[i]); i--; end
    end
    scale = 4 * k + e;
    sig = 512'd1; nf = 0;
    while (i >= 0) begin sig = (sig << 1) | 512'(m[i]); nf++; i--; end
  endfunction

  function automatic logic [511:0] ref_step(input logic [511:0] acc, input logic [1:0] op,
                                            input logic [31:0] a, input logic [31:0] b);
    bit na, nb;
    int sa, sb, fa, fb, sh;
    logic [511:0] ga, gb, pr;
    if (op == 2'b00) return '0;
    if (op == 2'b01) return -acc;
    if (a == 32'h8000_0000 || b == 32'h8000_0000) return NAR;
    if (acc == NAR || a == 0 || b == 0) return acc;
    ref_decode(a, na, sa, ga, fa);
    ref_decode(b, nb, sb, gb, fb);
    pr = ga * gb;
    sh = sa + sb - fa - fb + 240;
    pr = (sh >= 0) ? (pr << sh) : (pr >> (-sh));
    if ((op == 2'b11) ^ (na ^ nb)) return acc - pr;
    return acc + pr;
  endfunction

  task automatic do_cmd(input string req, input logic [1:0] op,
                        input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_a = a; cmd_b = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " R2 busy"}, 512'(busy), 512'd1);
    @(negedge clk);
    model = ref_step(model, op, a, b);
    check({req, " R2 done"}, 512'(done), 512'd1);
    check(req, acc_q, model);
  endtask

  initial begin
    logic [511:0] held;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 acc", acc_q, '0);
    check("R1 busy", 512'(busy), '0);
    check("R1 done", 512'(done), '0);

    do_cmd("R5 one*one", 2'b10, 32'h4000_0000, 32'h4000_0000);
    check("R5 bit240", acc_q, 512'd1 << 240);
    do_cmd("R6 msub", 2'b11, 32'h4000_0000, 32'h4000_0000);
    check("R6 zero", acc_q, '0);
    do_cmd("R5 neg one", 2'b10, 32'hC000_0000, 32'h4000_0000);
    do_cmd("R4 negate", 2'b01, 0, 0);
    check("R4 plus", acc_q, 512'd1 << 240);
    do_cmd("R3 clear", 2'b00, 0, 0);
    do_cmd("R4 negate zero", 2'b01, 0, 0);
    do_cmd("R11 minpos sq", 2'b10, 32'h0000_0001, 32'h0000_0001);
    check("R11 bit0", acc_q, 512'd1);
    do_cmd("R11 maxpos sq", 2'b10, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    check("R11 bit480", acc_q, (512'd1 << 480) + 512'd1);
    do_cmd("R9 zero op", 2'b10, 32'h0000_0000, 32'h5123_4567);
    do_cmd("R9 zero op sub", 2'b11, 32'h3ABC_0001, 32'h0000_0000);
    do_cmd("R7 nar op", 2'b10, 32'h8000_0000, 32'h4000_0000);
    check("R7 flag", 512'(acc_nar), 512'd1);
    do_cmd("R8 madd on nar", 2'b10, 32'h4000_0000, 32'h4000_0000);
    do_cmd("R8 msub on nar", 2'b11, 32'h2000_0000, 32'h6000_0000);
    do_cmd("R8 negate nar", 2'b01, 0, 0);
    check("R8 pattern", acc_q, NAR);
    do_cmd("R3 clear nar", 2'b00, 0, 0);

    // R10: load when idle
    @(negedge clk);
    load_valid = 1'b1; load_data = {16{32'h1357_9BDF}};
    @(negedge clk);
    load_valid = 1'b0;
    model = {16{32'h1357_9BDF}};
    check("R10 load", acc_q, model);
    // R10: load ignored when a command is presented together
    @(negedge clk);
    load_valid = 1'b1; load_data = {16{32'hFFFF_0000}};
    cmd_valid = 1'b1; cmd_op = 2'b01; cmd_a = 0; cmd_b = 0;
    @(negedge clk);
    cmd_valid = 1'b0;
    @(negedge clk);
    load_valid = 1'b0;
    model = -model;
    check("R10 load ignored", acc_q, model);

    // R2: command held during busy must not execute twice
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'b10; cmd_a = 32'h4000_0000; cmd_b = 32'h4800_0000;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    model = ref_step(model, 2'b10, 32'h4000_0000, 32'h4800_0000);
    held = acc_q;
    check("R2 first result", held, model);
    @(negedge clk);
    check("R2 no second done", 512'(done), '0);
    check("R2 ignored while busy", acc_q, held);

    // Seeded random mix
    do_cmd("R3 clear", 2'b00, 0, 0);
    for (int n = 0; n < 300; n++) begin
      logic [31:0] ra, rb, pick;
      logic [1:0]  op;
      pick = $urandom % 40;
      op = (pick < 3) ? 2'b00 : (pick < 6) ? 2'b01 : (pick < 23) ? 2'b10 : 2'b11;
      ra = $urandom; rb = $urandom;
      if ($urandom % 16 == 0) ra = 0;
      if ($urandom % 64 == 0) rb = 32'h8000_0000;
      if ($urandom % 2 == 0) rb = {rb[31], 4'b0100, rb[26:0]} ^ 32'h0000_0000;
      do_cmd("R5 R6 random", op, ra, rb);
    end
    summary();
  end
endmodule